// File: doc/BRIEF.md
# Boot ROM and Window Chip-Select Decoder

This block watches the address and command strobes of a legacy expansion bus and produces two active-low chip selects: one for the boot ROM or flash device and one for a programmable memory window. After reset the ROM select claims a small region just below 1 MB and a small region at the top of the 4 GB space. Software can widen both regions, allow writes to reach the flash, and place a power-of-two window anywhere in memory. The window select comes with its own read and write qualifiers. Two merged strobes combine the memory and I/O commands.

Each select also comes with a data-width attribute and a zero-wait attribute. The ROM width is taken from a strap pin while reset is held, and software can change it later. All selects and strobes are combinational from the current bus inputs and the registered configuration. Configuration writes are applied on the rising clock edge. The reset is synchronous.

Top module: `bootsel_decoder`

## Requirements
- R1: After reset, a memory read asserts romCsN exactly when the address is in 0x000F0000..0x000FFFFF or 0xFFFC0000..0xFFFFFFFF.
- R2: Control register (cfgAddr 0) bit 0 adds 0x000E0000..0x000EFFFF to the low ROM region. Bit 1 widens the high ROM region to 0xFF000000..0xFFFFFFFF.
- R3: A memory write to the ROM region leaves romCsN high unless control bit 2 is set. When bit 2 is set, romCsN goes low together with wrN.
- R4: When the window is enabled, winCsN is low for a memory read or write whose address lies in the window. The window start is the base register (cfgAddr 1) with the bits below the window size cleared.
- R5: The size register (cfgAddr 2) holds log2 of the window size. Values below 12 are clamped to 12 (4 KB) and values above 24 are clamped to 24 (16 MB).
- R6: The window is disabled after reset. It is enabled by control bit 3.
- R7: An address inside an active ROM region never asserts winCsN, even if it also lies inside the window.
- R8: winRdN is low only when winCsN and memRdN are both low. winWrN is low only when winCsN and memWrN are both low.
- R9: rdN is low when memRdN or ioRdN is low. wrN is low when memWrN or ioWrN is low.
- R10: romWide takes the value of strapWide while reset is held. Strap changes after reset have no effect. Control bit 4 later sets romWide and control bit 5 sets winWide.
- R11: Control bit 6 drives romZeroWait and control bit 7 drives winZeroWait. Each flag is independent of the width bits.
- R12: I/O read and write cycles assert neither chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapWide | input | 1 | ROM width strap (1 = 16-bit), captured while reset is held |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgAddr | input | 2 | Register select: 0 control, 1 window base, 2 window size log2 |
| cfgWrData | input | 32 | Configuration write data |
| busAddr | input | 32 | Bus memory address |
| memRdN | input | 1 | Memory read command, active low |
| memWrN | input | 1 | Memory write command, active low |
| ioRdN | input | 1 | I/O read command, active low |
| ioWrN | input | 1 | I/O write command, active low |
| romCsN | output | 1 | ROM chip select, active low |
| winCsN | output | 1 | Window chip select, active low |
| winRdN | output | 1 | Window read qualifier, active low |
| winWrN | output | 1 | Window write qualifier, active low |
| rdN | output | 1 | Merged read strobe, active low |
| wrN | output | 1 | Merged write strobe, active low |
| romWide | output | 1 | ROM data width, 1 = 16-bit |
| romZeroWait | output | 1 | ROM zero-wait attribute |
| winWide | output | 1 | Window data width, 1 = 16-bit |
| winZeroWait | output | 1 | Window zero-wait attribute |

## Verification
The assertions assume that no more than one command strobe is low in any cycle. Under that assumption, a cycle with both memory strobes high is an I/O or idle cycle and the qualifier checks are meaningful. The bench drives only one command at a time, and it changes the address and strobes only at the falling clock edge. Configuration writes are separate from bus cycles, so every comparison sees a settled configuration.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int ADDR_W = 32;

  typedef struct packed {
    logic              romLowExt;
    logic              romHighExt;
    logic              romWrEn;
    logic              winEn;
    logic [ADDR_W-1:0] winBase;
    logic [ADDR_W-1:0] winMask;
  } decCfg_t;
endpackage

// File: rtl/bsd_ctrl.sv
module bsd_ctrl
  import bsd_pkg::*;
#(
  parameter int MIN_LOG2 = 12,
  parameter int MAX_LOG2 = 24,
  parameter int SIZE_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapWide,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWrData,
  output decCfg_t           cfg,
  output logic              romWide,
  output logic              winWide,
  output logic              romZeroWait,
  output logic              winZeroWait
);
  localparam logic [1:0] REG_CTL  = 2'd0;
  localparam logic [1:0] REG_BASE = 2'd1;
  localparam logic [1:0] REG_SIZE = 2'd2;
  localparam int         CTL_W    = 8;

  logic [CTL_W-1:0]  ctlReg;
  logic [ADDR_W-1:0] baseReg;
  logic [SIZE_W-1:0] sizeLog2;
  logic [SIZE_W-1:0] sizeNext;

  always_comb begin
    if (cfgWrData < ADDR_W'(MIN_LOG2))      sizeNext = SIZE_W'(MIN_LOG2);
    else if (cfgWrData > ADDR_W'(MAX_LOG2)) sizeNext = SIZE_W'(MAX_LOG2);
    else                                    sizeNext = cfgWrData[SIZE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg    <= '0;
      ctlReg[4] <= strapWide;
      baseReg   <= '0;
      sizeLog2  <= SIZE_W'(MIN_LOG2);
    end else if (cfgWrEn) begin
      case (cfgAddr)
        REG_CTL:  ctlReg   <= cfgWrData[CTL_W-1:0];
        REG_BASE: baseReg  <= cfgWrData;
        REG_SIZE: sizeLog2 <= sizeNext;
        default:  ;
      endcase
    end
  end

  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    assign cfg.winMask[i] = (i >= int'(sizeLog2));
  end

  assign cfg.romLowExt  = ctlReg[0];
  assign cfg.romHighExt = ctlReg[1];
  assign cfg.romWrEn    = ctlReg[2];
  assign cfg.winEn      = ctlReg[3];
  assign cfg.winBase    = baseReg;
  assign romWide        = ctlReg[4];
  assign winWide        = ctlReg[5];
  assign romZeroWait    = ctlReg[6];
  assign winZeroWait    = ctlReg[7];
endmodule

// File: rtl/bsd_dpath.sv
module bsd_dpath
  import bsd_pkg::*;
(
  input  decCfg_t           cfg,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              memRdN,
  input  logic              memWrN,
  input  logic              ioRdN,
  input  logic              ioWrN,
  output logic              romCsN,
  output logic              winCsN,
  output logic              winRdN,
  output logic              winWrN,
  output logic              rdN,
  output logic              wrN
);
  localparam logic [15:0] LOW_PAGE     = 16'h000F;
  localparam logic [15:0] LOW_EXT_PAGE = 16'h000E;
  localparam int          HI_BITS      = 14;
  localparam int          HI_EXT_BITS  = 8;

  logic memRd, memWr, romLowHit, romHighHit, romHit, winHit, winCs;

  assign memRd = !memRdN;
  assign memWr = !memWrN;

  assign romLowHit  = (busAddr[ADDR_W-1:16] == LOW_PAGE) ||
                      (cfg.romLowExt && busAddr[ADDR_W-1:16] == LOW_EXT_PAGE);
  assign romHighHit = (&busAddr[ADDR_W-1 -: HI_BITS]) ||
                      (cfg.romHighExt && (&busAddr[ADDR_W-1 -: HI_EXT_BITS]));
  assign romHit     = romLowHit || romHighHit;

  assign winHit = cfg.winEn && (((busAddr ^ cfg.winBase) & cfg.winMask) == '0);
  assign winCs  = winHit && !romHit && (memRd || memWr);

  assign romCsN = !(romHit && (memRd || (memWr && cfg.romWrEn)));
  assign winCsN = !winCs;
  assign winRdN = !(winCs && memRd);
  assign winWrN = !(winCs && memWr);
  assign rdN    = memRdN && ioRdN;
  assign wrN    = memWrN && ioWrN;
endmodule

// File: rtl/bootsel_decoder.sv
module bootsel_decoder
  import bsd_pkg::*;
#(
  parameter int MIN_LOG2 = 12,
  parameter int MAX_LOG2 = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapWide,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              memRdN,
  input  logic              memWrN,
  input  logic              ioRdN,
  input  logic              ioWrN,
  output logic              romCsN,
  output logic              winCsN,
  output logic              winRdN,
  output logic              winWrN,
  output logic              rdN,
  output logic              wrN,
  output logic              romWide,
  output logic              romZeroWait,
  output logic              winWide,
  output logic              winZeroWait
);
  localparam int SIZE_W = $clog2(MAX_LOG2 + 1);

  decCfg_t decCfg;

  bsd_ctrl #(.MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2), .SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .strapWide(strapWide), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .cfg(decCfg),
    .romWide(romWide), .winWide(winWide),
    .romZeroWait(romZeroWait), .winZeroWait(winZeroWait)
  );

  bsd_dpath u_dpath (
    .cfg(decCfg), .busAddr(busAddr), .memRdN(memRdN), .memWrN(memWrN),
    .ioRdN(ioRdN), .ioWrN(ioWrN), .romCsN(romCsN), .winCsN(winCsN),
    .winRdN(winRdN), .winWrN(winWrN), .rdN(rdN), .wrN(wrN)
  );
endmodule

// File: rtl/bootsel_decoder_chk.sv
module bootsel_decoder_chk
  import bsd_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    memRdN,
  input logic    memWrN,
  input logic    ioRdN,
  input logic    ioWrN,
  input logic    romCsN,
  input logic    winCsN,
  input logic    winRdN,
  input logic    winWrN,
  input logic    rdN,
  input logic    wrN,
  input decCfg_t cfg
);
  // R8: the read qualifier needs both the window select and a memory read
  p_win_rd_qual_r8: assert property (@(posedge clk) disable iff (!rstN)
    !winRdN |-> (!winCsN && !memRdN));
  // R8: the write qualifier needs both the window select and a memory write
  p_win_wr_qual_r8: assert property (@(posedge clk) disable iff (!rstN)
    !winWrN |-> (!winCsN && !memWrN));
  p_rom_priority_r7: assert property (@(posedge clk) disable iff (!rstN)
    !romCsN |-> winCsN);
  p_merged_rd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!memRdN || !ioRdN) |-> !rdN);
  p_merged_wr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!memWrN || !ioWrN) |-> !wrN);
  p_io_no_cs_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memRdN && memWrN) |-> (romCsN && winCsN));
  // R3: a ROM select during a pure memory write needs the write enable
  p_rom_wr_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!romCsN && memRdN) |-> cfg.romWrEn);
  p_win_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.winEn |-> winCsN);
  p_size_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.winMask[11:0] == 12'h000) && (&cfg.winMask[31:24]));
endmodule

bind bootsel_decoder bootsel_decoder_chk u_chk (
  .clk(clk), .rstN(rstN), .memRdN(memRdN), .memWrN(memWrN),
  .ioRdN(ioRdN), .ioWrN(ioWrN), .romCsN(romCsN), .winCsN(winCsN),
  .winRdN(winRdN), .winWrN(winWrN), .rdN(rdN), .wrN(wrN), .cfg(decCfg)
);

// File: tb/bootsel_decoder_bench.sv
module bootsel_decoder_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapWide = 1'b1;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] busAddr = '0;
  logic memRdN = 1'b1, memWrN = 1'b1, ioRdN = 1'b1, ioWrN = 1'b1;
  logic romCsN, winCsN, winRdN, winWrN, rdN, wrN;
  logic romWide, romZeroWait, winWide, winZeroWait;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural model state
  bit mLowExt, mHighExt, mWrEn, mWinEn, mRomWide, mWinWide, mRomZw, mWinZw;
  longint unsigned mBase = 0;
  int mLog2 = 12;

  always #5 clk = ~clk;

  bootsel_decoder u_bootsel_decoder (
    .clk(clk), .rstN(rstN), .strapWide(strapWide), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .busAddr(busAddr),
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .romCsN(romCsN), .winCsN(winCsN), .winRdN(winRdN), .winWrN(winWrN),
    .rdN(rdN), .wrN(wrN), .romWide(romWide), .romZeroWait(romZeroWait),
    .winWide(winWide), .winZeroWait(winZeroWait)
  );

  function automatic bit inRom(longint unsigned a);
    bit low, high;
    low  = (a >= 64'h000F0000 && a <= 64'h000FFFFF) ||
           (mLowExt && a >= 64'h000E0000 && a <= 64'h000EFFFF);
    high = (a >= 64'hFFFC0000) || (mHighExt && a >= 64'hFF000000);
    return low || high;
  endfunction

  function automatic logic [9:0] expected(longint unsigned a, bit mr, bit mw, bit ir, bit iw);
    longint unsigned size, lo;
    bit rom, win, romCs, winCs;
    size  = 64'd1 << mLog2;
    lo    = mBase - (mBase % size);
    rom   = inRom(a);
    win   = mWinEn && a >= lo && a < lo + size;
    romCs = rom && (mr || (mw && mWrEn));
    winCs = win && !rom && (mr || mw);
    return {!romCs, !winCs, !(winCs && mr), !(winCs && mw), !(mr || ir), !(mw || iw),
            1'(mRomWide), 1'(mRomZw), 1'(mWinWide), 1'(mWinZw)};
  endfunction

  task automatic cfgWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    case (a)
      2'd0: begin
        mLowExt = d[0]; mHighExt = d[1]; mWrEn = d[2]; mWinEn = d[3];
        mRomWide = d[4]; mWinWide = d[5]; mRomZw = d[6]; mWinZw = d[7];
      end
      2'd1: mBase = longint'(d);
      2'd2: mLog2 = (d < 12) ? 12 : (d > 24) ? 24 : int'(d);
      default: ;
    endcase
  endtask

  // cmd: 0 idle, 1 mem rd, 2 mem wr, 3 io rd, 4 io wr
  task automatic bus(input logic [31:0] a, input int cmd, input string tag);
    logic [9:0] act, exp;
    @(negedge clk);
    busAddr = a;
    memRdN = !(cmd == 1); memWrN = !(cmd == 2);
    ioRdN = !(cmd == 3); ioWrN = !(cmd == 4);
    #2;
    exp = expected(longint'(a), cmd == 1, cmd == 2, cmd == 3, cmd == 4);
    act = {romCsN, winCsN, winRdN, winWrN, rdN, wrN, romWide, romZeroWait, winWide, winZeroWait};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h cmd=%0d actual=%b expected=%b", tag, a, cmd, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    mRomWide = 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    strapWide = 1'b0;                      // R10: ignored after reset
    bus(32'h0, 0, "R10 reset state and strap");
    // R1
    bus(32'h000F0000, 1, "R1 low start");
    bus(32'h000FFFFF, 1, "R1 low end");
    bus(32'h000EFFFF, 1, "R1 below low");
    bus(32'hFFFC0000, 1, "R1 high start");
    bus(32'hFFFBFFFF, 1, "R1 below high");
    bus(32'h00100000, 1, "R1 above low");
    // R3 blocked, R12, R9
    bus(32'hFFFFFFF0, 2, "R3 write blocked");
    bus(32'h000F0000, 3, "R12 io read");
    bus(32'hFFFF0000, 4, "R12 io write R9");
    // R2
    cfgWrite(2'd0, 32'h03);
    bus(32'h000E0000, 1, "R2 low ext");
    bus(32'hFF000000, 1, "R2 high ext");
    bus(32'hFEFFFFFF, 1, "R2 below high ext");
    bus(32'h000DFFFF, 1, "R2 below low ext");
    // R3 enabled
    cfgWrite(2'd0, 32'h07);
    bus(32'hFFFFFFF0, 2, "R3 write enabled");
    bus(32'h000E1000, 2, "R3 low write enabled");
    // R6 window off, then R4
    cfgWrite(2'd1, 32'h10001234);
    cfgWrite(2'd2, 32'd16);
    bus(32'h10000000, 1, "R6 window disabled");
    cfgWrite(2'd0, 32'h0B);
    bus(32'h10000000, 1, "R4 window start R8");
    bus(32'h1000FFFF, 2, "R4 window end write R8");
    bus(32'h10010000, 1, "R4 above window");
    bus(32'h0FFFFFFF, 2, "R4 below window");
    bus(32'h10004000, 3, "R12 io in window");
    // R5 clamps
    cfgWrite(2'd2, 32'd5);
    bus(32'h10001000, 1, "R5 clamp low hit");
    bus(32'h10002000, 1, "R5 clamp low miss");
    cfgWrite(2'd2, 32'd40);
    bus(32'h10FFFFFF, 1, "R5 clamp high hit");
    bus(32'h11000000, 1, "R5 clamp high miss");
    // R7 priority
    cfgWrite(2'd1, 32'hFF000000);
    bus(32'hFF800000, 1, "R7 rom over window");
    bus(32'hFFFD0000, 2, "R7 rom range, write blocked");
    cfgWrite(2'd0, 32'h08);
    bus(32'hFF800000, 1, "R7 window when rom off");
    bus(32'hFFFD0000, 1, "R7 base rom still wins");
    // R10 R11 attributes
    cfgWrite(2'd0, 32'h68);
    bus(32'h0, 0, "R10 R11 attributes a");
    cfgWrite(2'd0, 32'h98);
    bus(32'h0, 0, "R10 R11 attributes b");
    // random mix (R8 and all outputs)
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      int sel;
      if (i % 50 == 0)
        cfgWrite(2'($urandom_range(0, 2)), $urandom());
      sel = $urandom_range(0, 3);
      case (sel)
        0: a = 32'hFF000000 | ($urandom() & 32'h00FFFFFF);
        1: a = 32'h000E0000 | ($urandom() & 32'h0003FFFF);
        2: a = 32'(mBase) ^ ($urandom() & 32'h01FFFFFF);
        default: a = $urandom();
      endcase
      bus(a, $urandom_range(0, 4), "R8 random");
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule